// File: doc/BRIEF.md
# Reduced Power and Emulation Mode Controller

This block decides which operating mode a small microcontroller core is in. It also drives the clock and pin-control enables that follow from that mode. The modes are normal run, idle, power-down, a wake-up phase while the oscillator settles, an in-circuit emulation mode, and reset. Software asks for idle or power-down with one-cycle request pulses. Two active-low external interrupt pins can bring the core out of power-down. An aggregate "enabled interrupt pending" line ends idle. The reset pin is qualified on a machine-cycle tick. The tick comes from an internal divider of the system clock.

Power-down stops the oscillator and ends in one of two ways. The first is a qualified reset. The second is an external interrupt that is enabled, configured as level-sensitive, and seen low on two consecutive machine-cycle samples. A wake restarts the oscillator at once. The CPU clock comes back only when two conditions hold: a programmable number of oscillator-stable cycles has been counted, and the interrupt pin that caused the wake has returned high. Emulation mode is chosen at reset release from the address-latch and program-strobe pin levels. In that mode the multiplexed port floats, the other pins get weak pull-ups, and only a new reset returns the core to normal.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The reset pin is sampled once per machine cycle (every MC_LEN clocks). Reset mode is entered only after two consecutive samples read high; a single high sample has no effect. In reset mode `sfr_rst`=1, `cpu_clk_en`=0 and `osc_run_en`=1. Reset mode ends after the first sample that reads low.
- R2: In run mode `cpu_clk_en`, `periph_clk_en` and `osc_run_en` are all 1. A `pd_req` pulse enters power-down and an `idle_req` pulse enters idle. If both requests arrive in the same cycle, power-down wins.
- R3: In idle `cpu_clk_en`=0 while `periph_clk_en`=1 and `osc_run_en`=1. When `irq_any`=1 the block returns to run on the next clock edge and raises `irq_wake` for exactly one cycle.
- R4: In power-down `osc_run_en`, `cpu_clk_en` and `periph_clk_en` are all 0, and `irq_any` has no effect.
- R5: Power-down ends on interrupt i (bit i of each vector) only when `xint_en[i]`=1 and `xint_lvl[i]`=1 (1 = level-sensitive), and `xint_n[i]` reads 0 on two consecutive machine-cycle samples. Any other enable/level setting, or a single low sample, leaves power-down in force.
- R6: After a wake is detected, `osc_run_en`=1 from the next cycle on. The CPU clock stays off until two conditions hold: `settle_cnt` cycles with `osc_stable`=1 have been counted, and every waking pin reads high. On the following edge the block enters run mode with a one-cycle `irq_wake` pulse. With `settle_cnt`=S and the pin already released, `cpu_clk_en` rises S+1 cycles after `osc_run_en` rises.
- R7: A qualified reset ends idle, power-down, wake-up and emulation, and raises `sfr_rst`. An interrupt exit never raises `sfr_rst`.
- R8: Emulation mode is entered when, during reset mode, `ale_pin`=0 is seen while `psen_pin`=1, and `ale_pin` is still 0 in the cycle reset mode ends.
- R9: In emulation mode `port0_float`=1, `weak_pullup`=1, `osc_run_en`=1 and `cpu_clk_en`=0. Power-down, idle and interrupt inputs are ignored, and only a qualified reset leaves the mode.
- R10: If `ale_pin` is high when reset mode ends, or `psen_pin` was low while `ale_pin` was low, the block enters run mode with `port0_float`=0 and `weak_pullup`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all machine-cycle timing is derived from it |
| rst_n | input | 1 | Active-low power-on reset of the controller logic |
| rst_pin | input | 1 | Raw device reset pin, active high |
| idle_req | input | 1 | Software request to enter idle (one-cycle pulse) |
| pd_req | input | 1 | Software request to enter power-down (one-cycle pulse) |
| xint_en | input | NUM_XINT | Enable of each external interrupt |
| xint_lvl | input | NUM_XINT | 1 = level-sensitive configuration of each external interrupt |
| xint_n | input | NUM_XINT | External interrupt pins, active low |
| irq_any | input | 1 | Any enabled interrupt pending |
| ale_pin | input | 1 | Address-latch pin level, sampled at reset |
| psen_pin | input | 1 | Program-strobe pin level, sampled at reset |
| osc_stable | input | 1 | High in each cycle the restarted oscillator counts as stable |
| settle_cnt | input | SETTLE_W | Number of stable cycles required after a wake |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_run_en | output | 1 | Oscillator run enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| port0_float | output | 1 | Float the multiplexed address/data port |
| weak_pullup | output | 1 | Weak pull-up on the other ports and strobe pins |
| irq_wake | output | 1 | One-cycle flag: run mode resumed through an interrupt |
| sfr_rst | output | 1 | Reinitialise special registers (reset mode active) |

## Verification
The bench builds the block with MC_LEN=4, NUM_XINT=2 and SETTLE_W=4. With these values a machine cycle lasts four clocks, so the bench can time the one-sample and two-sample windows of the reset and wake qualifiers to the clock. It sweeps all four enable/level settings on each interrupt pin and checks that only the enabled, level-sensitive setting wakes the core. It also sweeps several settle counts, including zero, and checks the exact CPU-clock restart cycle against S+1. The emulation strap is tried with every decisive combination of address-latch and program-strobe levels.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        MODE_RESET = 3'd0,
        MODE_RUN   = 3'd1,
        MODE_IDLE  = 3'd2,
        MODE_PDOWN = 3'd3,
        MODE_WAKE  = 3'd4,
        MODE_EMU   = 3'd5
    } pmc_mode_e;

endpackage

// File: rtl/pmc_tick.sv
// Machine-cycle tick: one pulse every MC_LEN system clocks.
module pmc_tick #(
    parameter int MC_LEN = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (MC_LEN > 2) ? $clog2(MC_LEN) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(MC_LEN - 1));
        cnt_d = tick ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pmc_rst_qual.sv
// Reset-pin qualifier: two consecutive high samples on the tick.
module pmc_rst_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic active
);
    logic [1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick) begin
            if (!pin)               cnt_d = 2'd0;
            else if (cnt_q != 2'd2) cnt_d = cnt_q + 2'd1;
        end
        active = (cnt_q == 2'd2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= 2'd0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pmc_wake_sense.sv
// Per-interrupt low-level detector: two consecutive low samples on the tick,
// qualified by enable and level-sensitive configuration.
module pmc_wake_sense #(
    parameter int NUM_XINT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [NUM_XINT-1:0] en,
    input  logic [NUM_XINT-1:0] lvl,
    input  logic [NUM_XINT-1:0] pin_n,
    output logic [NUM_XINT-1:0] hit
);
    for (genvar g = 0; g < NUM_XINT; g++) begin : g_line
        logic low_d, low_q;

        always_comb begin
            low_d  = tick ? ~pin_n[g] : low_q;
            hit[g] = tick & en[g] & lvl[g] & ~pin_n[g] & low_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) low_q <= 1'b0;
            else        low_q <= low_d;
        end
    end
endmodule

// File: rtl/pmc_settle.sv
// Counts oscillator-stable cycles while the wake phase is active.
module pmc_settle #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                stable,
    input  logic [SETTLE_W-1:0] limit,
    output logic                done
);
    logic [SETTLE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        done = (cnt_q >= limit);
        if (!run)                 cnt_d = '0;
        else if (stable && !done) cnt_d = cnt_q + SETTLE_W'(1);
        else                      cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int MC_LEN   = 12,
    parameter int NUM_XINT = 2,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_pin,
    input  logic                idle_req,
    input  logic                pd_req,
    input  logic [NUM_XINT-1:0] xint_en,
    input  logic [NUM_XINT-1:0] xint_lvl,
    input  logic [NUM_XINT-1:0] xint_n,
    input  logic                irq_any,
    input  logic                ale_pin,
    input  logic                psen_pin,
    input  logic                osc_stable,
    input  logic [SETTLE_W-1:0] settle_cnt,
    output logic                cpu_clk_en,
    output logic                osc_run_en,
    output logic                periph_clk_en,
    output logic                port0_float,
    output logic                weak_pullup,
    output logic                irq_wake,
    output logic                sfr_rst
);
    typedef struct packed {
        pmc_mode_e           mode;
        logic [NUM_XINT-1:0] src;
        logic                once_arm;
        logic                wake_pulse;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic                tick;
    logic                rst_act;
    logic [NUM_XINT-1:0] hit;
    logic                settle_done;
    logic                released;

    pmc_tick #(.MC_LEN(MC_LEN)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    pmc_rst_qual u_rst_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .pin   (rst_pin),
        .active(rst_act)
    );

    pmc_wake_sense #(.NUM_XINT(NUM_XINT)) u_wake_sense (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .en   (xint_en),
        .lvl  (xint_lvl),
        .pin_n(xint_n),
        .hit  (hit)
    );

    pmc_settle #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q.mode == MODE_WAKE),
        .stable(osc_stable),
        .limit (settle_cnt),
        .done  (settle_done)
    );

    // A wake completes only once every pin that caused it reads high again.
    assign released = &(xint_n | ~ctrl_q.src);

    always_comb begin
        ctrl_d            = ctrl_q;
        ctrl_d.wake_pulse = 1'b0;

        // Emulation strap: armed by address-latch low with strobe high.
        if (ctrl_q.mode == MODE_RESET) begin
            if (!ale_pin && psen_pin) ctrl_d.once_arm = 1'b1;
            else if (ale_pin)         ctrl_d.once_arm = 1'b0;
        end else begin
            ctrl_d.once_arm = 1'b0;
        end

        if (rst_act) begin
            ctrl_d.mode = MODE_RESET;
        end else begin
            unique case (ctrl_q.mode)
                MODE_RESET: ctrl_d.mode = (ctrl_q.once_arm && !ale_pin) ? MODE_EMU : MODE_RUN;
                MODE_RUN: begin
                    if (pd_req)        ctrl_d.mode = MODE_PDOWN;
                    else if (idle_req) ctrl_d.mode = MODE_IDLE;
                end
                MODE_IDLE: begin
                    if (irq_any) begin
                        ctrl_d.mode       = MODE_RUN;
                        ctrl_d.wake_pulse = 1'b1;
                    end
                end
                MODE_PDOWN: begin
                    if (|hit) begin
                        ctrl_d.mode = MODE_WAKE;
                        ctrl_d.src  = hit;
                    end
                end
                MODE_WAKE: begin
                    if (settle_done && released) begin
                        ctrl_d.mode       = MODE_RUN;
                        ctrl_d.wake_pulse = 1'b1;
                    end
                end
                MODE_EMU: ctrl_d.mode = MODE_EMU;
                default:  ctrl_d.mode = MODE_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.mode       <= MODE_RESET;
            ctrl_q.src        <= '0;
            ctrl_q.once_arm   <= 1'b0;
            ctrl_q.wake_pulse <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        cpu_clk_en    = (ctrl_q.mode == MODE_RUN);
        periph_clk_en = (ctrl_q.mode == MODE_RUN) || (ctrl_q.mode == MODE_IDLE);
        osc_run_en    = (ctrl_q.mode != MODE_PDOWN);
        port0_float   = (ctrl_q.mode == MODE_EMU);
        weak_pullup   = (ctrl_q.mode == MODE_EMU);
        sfr_rst       = (ctrl_q.mode == MODE_RESET);
        irq_wake      = ctrl_q.wake_pulse;
    end
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
    input logic clk,
    input logic rst_n,
    input logic pd_req,
    input logic cpu_clk_en,
    input logic osc_run_en,
    input logic periph_clk_en,
    input logic port0_float,
    input logic irq_wake,
    input logic sfr_rst
);
    assert_run_clocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (osc_run_en && periph_clk_en));

    assert_pd_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && pd_req) |=> (!osc_run_en || sfr_rst));

    assert_wake_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wake |-> (cpu_clk_en && !$past(cpu_clk_en)));

    assert_pd_no_direct_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run_en |=> !cpu_clk_en);

    assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rst |-> (!cpu_clk_en && !irq_wake && osc_run_en));

    assert_emu_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        port0_float |=> (port0_float || sfr_rst));
endmodule

bind pwr_mode_ctrl pmc_checker u_pmc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_req       (pd_req),
    .cpu_clk_en   (cpu_clk_en),
    .osc_run_en   (osc_run_en),
    .periph_clk_en(periph_clk_en),
    .port0_float  (port0_float),
    .irq_wake     (irq_wake),
    .sfr_rst      (sfr_rst)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MC         = 4;
    localparam int NX         = 2;
    localparam int SW         = 4;
    localparam int WATCHDOG   = 100000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rst_pin, idle_req, pd_req, irq_any;
    logic [NX-1:0] xint_en, xint_lvl, xint_n;
    logic          ale_pin, psen_pin, osc_stable;
    logic [SW-1:0] settle_cnt;
    logic          cpu_clk_en, osc_run_en, periph_clk_en;
    logic          port0_float, weak_pullup, irq_wake, sfr_rst;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int sfr_seen = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwr_mode_ctrl #(.MC_LEN(MC), .NUM_XINT(NX), .SETTLE_W(SW)) u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .idle_req(idle_req),
        .pd_req(pd_req), .xint_en(xint_en), .xint_lvl(xint_lvl), .xint_n(xint_n),
        .irq_any(irq_any), .ale_pin(ale_pin), .psen_pin(psen_pin),
        .osc_stable(osc_stable), .settle_cnt(settle_cnt),
        .cpu_clk_en(cpu_clk_en), .osc_run_en(osc_run_en),
        .periph_clk_en(periph_clk_en), .port0_float(port0_float),
        .weak_pullup(weak_pullup), .irq_wake(irq_wake), .sfr_rst(sfr_rst)
    );

    always @(negedge clk) if (sfr_rst) sfr_seen++;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG && !done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_cycle(input string req);
        rst_pin = 1'b1;
        wait_n(3 * MC);
        chk({req, " reset mode sfr_rst"}, int'(sfr_rst), 1);
        rst_pin = 1'b0;
        wait_n(3 * MC);
    endtask

    task automatic enter_pd();
        pd_req = 1'b1;
        wait_n(1);
        pd_req = 1'b0;
    endtask

    // Wake through pin p with settle count s; pin released as soon as the oscillator restarts.
    task automatic wake_and_check(input int p, input int s);
        int waited;
        settle_cnt = SW'(s);
        xint_en = '0; xint_lvl = '0;
        xint_en[p] = 1'b1; xint_lvl[p] = 1'b1;
        sfr_seen = 0;
        xint_n[p] = 1'b0;
        waited = 0;
        while (!osc_run_en && waited < 4 * MC) begin
            wait_n(1);
            waited++;
        end
        chk("R5 qualified wake restarts oscillator", int'(osc_run_en), 1);
        chk("R6 cpu off when oscillator restarts", int'(cpu_clk_en), 0);
        xint_n[p] = 1'b1;
        if (s > 0) begin
            wait_n(s);
            chk("R6 cpu off until settle count", int'(cpu_clk_en), 0);
            wait_n(1);
        end else begin
            wait_n(1);
        end
        chk("R6 cpu on after settle", int'(cpu_clk_en), 1);
        chk("R6 irq_wake pulse on resume", int'(irq_wake), 1);
        wait_n(1);
        chk("R6 irq_wake single cycle", int'(irq_wake), 0);
        chk("R7 interrupt exit keeps sfr", sfr_seen, 0);
        xint_en = '0; xint_lvl = '0;
    endtask

    initial begin
        rst_n = 1'b0; rst_pin = 1'b1; idle_req = 1'b0; pd_req = 1'b0; irq_any = 1'b0;
        xint_en = '0; xint_lvl = '0; xint_n = '1;
        ale_pin = 1'b1; psen_pin = 1'b1; osc_stable = 1'b1; settle_cnt = SW'(3);
        wait_n(2);
        chk("R1 reset state sfr_rst", int'(sfr_rst), 1);
        chk("R1 reset state cpu off", int'(cpu_clk_en), 0);
        chk("R1 reset state osc on", int'(osc_run_en), 1);
        rst_n = 1'b1;
        wait_n(4 * MC);
        chk("R1 pin held keeps reset", int'(sfr_rst), 1);
        rst_pin = 1'b0;
        wait_n(3 * MC);
        chk("R2 run cpu", int'(cpu_clk_en), 1);
        chk("R2 run periph", int'(periph_clk_en), 1);
        chk("R2 run osc", int'(osc_run_en), 1);
        chk("R10 normal release no float", int'(port0_float), 0);

        // R1: one high sample is ignored, three are recognised
        sfr_seen = 0;
        rst_pin = 1'b1;
        wait_n(MC);
        rst_pin = 1'b0;
        wait_n(2 * MC);
        chk("R1 single sample ignored", sfr_seen, 0);
        chk("R1 single sample cpu still on", int'(cpu_clk_en), 1);
        reset_cycle("R1");
        chk("R1 back to run after release", int'(cpu_clk_en), 1);

        // R2: simultaneous requests, power-down wins; R7 reset exits power-down
        pd_req = 1'b1; idle_req = 1'b1;
        wait_n(1);
        pd_req = 1'b0; idle_req = 1'b0;
        chk("R2 pd priority osc off", int'(osc_run_en), 0);
        chk("R4 pd periph off", int'(periph_clk_en), 0);
        chk("R4 pd cpu off", int'(cpu_clk_en), 0);
        irq_any = 1'b1;
        wait_n(2);
        irq_any = 1'b0;
        chk("R4 irq_any ignored in pd", int'(osc_run_en), 0);
        reset_cycle("R7 pd");
        chk("R7 reset exit from pd to run", int'(cpu_clk_en), 1);

        // R3: idle and interrupt return
        idle_req = 1'b1;
        wait_n(1);
        idle_req = 1'b0;
        chk("R3 idle cpu off", int'(cpu_clk_en), 0);
        chk("R3 idle periph on", int'(periph_clk_en), 1);
        chk("R3 idle osc on", int'(osc_run_en), 1);
        wait_n(3);
        chk("R3 idle holds without irq", int'(cpu_clk_en), 0);
        irq_any = 1'b1;
        wait_n(1);
        irq_any = 1'b0;
        chk("R3 irq returns to run", int'(cpu_clk_en), 1);
        chk("R3 irq_wake pulse", int'(irq_wake), 1);
        wait_n(1);
        chk("R3 irq_wake single cycle", int'(irq_wake), 0);
        idle_req = 1'b1;
        wait_n(1);
        idle_req = 1'b0;
        reset_cycle("R7 idle");
        chk("R7 reset exit from idle", int'(cpu_clk_en), 1);

        // R5: sweep enable/level on each pin
        for (int p = 0; p < NX; p++) begin
            for (int cfg = 0; cfg < 3; cfg++) begin
                enter_pd();
                xint_en[p] = cfg[0]; xint_lvl[p] = cfg[1];
                xint_n[p] = 1'b0;
                wait_n(4 * MC);
                chk($sformatf("R5 pin%0d cfg%0d no wake", p, cfg), int'(osc_run_en), 0);
                xint_n[p] = 1'b1;
                xint_en = '0; xint_lvl = '0;
                reset_cycle("R5 recover");
            end
            enter_pd();
            wake_and_check(p, 2);
        end

        // R5: a single low sample does not wake
        enter_pd();
        xint_en[0] = 1'b1; xint_lvl[0] = 1'b1;
        xint_n[0] = 1'b0;
        wait_n(MC);
        xint_n[0] = 1'b1;
        wait_n(3 * MC);
        chk("R5 single low sample no wake", int'(osc_run_en), 0);
        wake_and_check(0, 1);

        // R6: settle count sweep
        for (int i = 0; i < 4; i++) begin
            enter_pd();
            wake_and_check(i % NX, (i == 0) ? 0 : (i * 3));
        end

        // R6: pin held low past settle keeps cpu off until release
        enter_pd();
        settle_cnt = SW'(2);
        xint_en[1] = 1'b1; xint_lvl[1] = 1'b1;
        xint_n[1] = 1'b0;
        wait_n(3 * MC + 6);
        chk("R6 held pin osc on", int'(osc_run_en), 1);
        chk("R6 held pin cpu off", int'(cpu_clk_en), 0);
        xint_n[1] = 1'b1;
        wait_n(1);
        chk("R6 release completes wake", int'(cpu_clk_en), 1);
        xint_en = '0; xint_lvl = '0;

        // R7: reset during wake phase
        enter_pd();
        settle_cnt = SW'(15);
        osc_stable = 1'b0;
        xint_en[0] = 1'b1; xint_lvl[0] = 1'b1;
        xint_n[0] = 1'b0;
        wait_n(3 * MC);
        xint_n[0] = 1'b1;
        chk("R6 no stable cycles cpu off", int'(cpu_clk_en), 0);
        reset_cycle("R7 wake");
        chk("R7 reset exit from wake", int'(cpu_clk_en), 1);
        osc_stable = 1'b1;
        xint_en = '0; xint_lvl = '0;

        // R8/R9: emulation entry and stickiness
        rst_pin = 1'b1; ale_pin = 1'b0; psen_pin = 1'b1;
        wait_n(3 * MC);
        rst_pin = 1'b0;
        wait_n(3 * MC);
        chk("R8 emulation port0 float", int'(port0_float), 1);
        chk("R9 emulation weak pullup", int'(weak_pullup), 1);
        chk("R9 emulation osc on", int'(osc_run_en), 1);
        chk("R9 emulation cpu off", int'(cpu_clk_en), 0);
        ale_pin = 1'b1;
        pd_req = 1'b1; wait_n(1); pd_req = 1'b0;
        idle_req = 1'b1; irq_any = 1'b1; wait_n(1); idle_req = 1'b0; irq_any = 1'b0;
        wait_n(2);
        chk("R9 requests ignored osc", int'(osc_run_en), 1);
        chk("R9 requests ignored float", int'(port0_float), 1);
        reset_cycle("R9 leave emu");
        chk("R9 reset leaves emulation", int'(port0_float), 0);
        chk("R10 run after plain reset", int'(cpu_clk_en), 1);

        // R10: strobe low while address latch low does not arm
        rst_pin = 1'b1; ale_pin = 1'b0; psen_pin = 1'b0;
        wait_n(3 * MC);
        rst_pin = 1'b0;
        wait_n(3 * MC);
        chk("R10 strobe low no emulation", int'(port0_float), 0);
        chk("R10 strobe low run", int'(cpu_clk_en), 1);
        psen_pin = 1'b1;

        // R10: armed but address latch high at release
        rst_pin = 1'b1; ale_pin = 1'b0;
        wait_n(3 * MC);
        ale_pin = 1'b1;
        wait_n(1);
        rst_pin = 1'b0;
        wait_n(3 * MC);
        chk("R10 latch high at release no emulation", int'(weak_pullup), 0);
        chk("R10 latch high at release run", int'(cpu_clk_en), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule